// File: doc/BRIEF.md
# Cascaded Serial DAC Chain Loader

This block is a host-side sequencer that loads a daisy chain of quad 8-bit DAC receivers over a two-wire serial link (data line, clock line) and then pulses an active-low load-DAC strobe so every receiver moves its held codes to its outputs at the same moment. The host hands over one 10-bit word per receiver (channel address in bits 9:8, code in bits 7:0) through a valid/ready handshake. After the configured number of words has arrived, the block sends one start condition. It then shifts out all words back to back, with a single zero bit between neighbouring words and no stop condition between them. The transfer closes with one stop condition, followed by the strobe.

Timing is set at run time in system-clock cycles: the clock half-period, the chain length, a per-device serial-output delay, and the strobe width. The stop setup phase and the stop-to-strobe gap are each stretched by the chain length times the per-device delay, so the stop condition ripples through every receiver before the strobe falls. The first word accepted is sent first and so ends up in the device farthest down the chain.

The controller is one state machine with these states: IDLE (collect words, lines high), START_A (data low, clock high), START_B (clock low), BIT_LO (clock low, present bit), BIT_HI (clock high, bit held), STOP_LO (clock low, data low), STOP_SCL (clock high, data low), STOP_SDA (data high) and LDAC (strobe low). The transitions are as follows. IDLE goes to START_A once the word count equals the chain length. START_A goes to START_B, and START_B goes to BIT_LO. BIT_LO and BIT_HI alternate until the final bit; after the final BIT_HI the machine goes to STOP_LO. The sequence then runs STOP_LO, STOP_SCL, STOP_SDA, LDAC and back to IDLE. Each state lasts its own programmed number of cycles. All three line outputs are registered, so each lags the state register by one cycle.

Top module: `cascade_dac_loader`

## Requirements
- R1: After reset and whenever idle, clock, data and strobe outputs are all 1 and busy is 0.
- R2: Ready is 1 while idle until chain-length words have been taken (valid and ready high at a rising edge). The transaction starts only once the count is reached, and ready is 1 again after it ends.
- R3: A transaction opens with data falling while clock is high. Clock falls exactly half-period cycles later, with data still 0. This is the only data fall while clock is high.
- R4: Each word is sent with bit 9 first and bit 0 last. Each bit is the data value present when clock falls. Words go out in acceptance order.
- R5: Exactly one 0 bit follows each word except the last, so a chain of N devices receives 11N-1 bits after the start.
- R6: While clock stays high during a word, data does not change.
- R7: The transaction closes with exactly one stop. Clock rises with data at 0, and data rises half-period + N·delay cycles later.
- R8: The strobe falls half-period + N·delay cycles after the stop data rise, only while both lines are high. It stays low for the programmed width.
- R9: Busy is 1 from the start condition until the strobe returns high. While busy, ready is 0 and offered words are not taken or sent.
- R10: Every clock-high phase inside a transaction lasts exactly the half-period in cycles. A zero half-period or strobe width acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_period | input | CNT_W | Serial clock half-period in cycles |
| num_dev | input | DEV_W | Number of receivers in the chain (1..MAX_DEV) |
| dev_delay | input | CNT_W | Per-device serial-output delay in cycles |
| ldac_width | input | CNT_W | Strobe low width in cycles |
| word_valid | input | 1 | Host offers a word |
| word_in | input | 10 | Address (9:8) and code (7:0) |
| word_ready | output | 1 | Block accepts a word |
| busy | output | 1 | Transaction in progress |
| scl | output | 1 | Serial clock line |
| sda | output | 1 | Serial data line |
| ldac_n | output | 1 | Active-low load-DAC strobe |

## Verification
The hardest case to reach is a host word offered while a transfer is running. The bench holds valid high with a marker word for many cycles of a live transfer. It then confirms that the marker never shows up in the decoded bit stream and does not shift the word count of the next transaction. Boundary cases use a zero per-device delay and unit widths, which make the stop and strobe phases collapse to their shortest form. A full eight-device chain exercises the last separator and the frame index limit.

// File: rtl/dac_loader_pkg.sv
package dac_loader_pkg;
    localparam int WORD_W = 10;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START_A,
        S_START_B,
        S_BIT_LO,
        S_BIT_HI,
        S_STOP_LO,
        S_STOP_SCL,
        S_STOP_SDA,
        S_LDAC
    } ldr_state_t;
endpackage

// File: rtl/dac_word_store.sv
module dac_word_store #(
    parameter int MAX_DEV = 8,
    parameter int IDX_W   = 4,
    parameter int WORD_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [3:0]        rd_bit,
    output logic              rd_value
);
    logic [WORD_W-1:0] slot_q [MAX_DEV];
    logic [WORD_W-1:0] sel_word;

    for (genvar g = 0; g < MAX_DEV; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                slot_q[g] <= wr_word;
        end
    end

    always_comb begin
        sel_word = '0;
        for (int i = 0; i < MAX_DEV; i++)
            if (rd_idx == IDX_W'(i))
                sel_word = slot_q[i];
    end

    // rd_bit counts from the top: 0 selects the most significant bit
    always_comb begin
        rd_value = 1'b0;
        for (int j = 0; j < WORD_W; j++)
            if (rd_bit == 4'(WORD_W - 1 - j))
                rd_value = sel_word[j];
    end
endmodule

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
    parameter int W = 21
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/cascade_dac_loader.sv
module cascade_dac_loader
    import dac_loader_pkg::*;
#(
    parameter int MAX_DEV = 8,
    parameter int CNT_W   = 16,
    parameter int DEV_W   = $clog2(MAX_DEV + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] half_period,
    input  logic [DEV_W-1:0] num_dev,
    input  logic [CNT_W-1:0] dev_delay,
    input  logic [CNT_W-1:0] ldac_width,
    input  logic             word_valid,
    input  logic [9:0]       word_in,
    output logic             word_ready,
    output logic             busy,
    output logic             scl,
    output logic             sda,
    output logic             ldac_n
);
    localparam int EXT_W = CNT_W + DEV_W + 1;
    localparam logic [DEV_W-1:0] ONE_D = DEV_W'(1);

    ldr_state_t st_q, st_d;
    logic [DEV_W-1:0] wcnt_q, fidx_q;
    logic [3:0]       bidx_q;
    logic             tmr_load, tmr_done, store_bit, bit_val, last_bit, accept;
    logic [EXT_W-1:0] half_ext, stop_ext, ldac_ext, tmr_val;
    logic             scl_c, sda_c, ldac_c;
    logic             scl_q, sda_q, ldac_q;

    assign half_ext = (half_period == '0) ? EXT_W'(1) : EXT_W'(half_period);
    assign ldac_ext = (ldac_width == '0) ? EXT_W'(1) : EXT_W'(ldac_width);
    assign stop_ext = half_ext + EXT_W'(num_dev) * EXT_W'(dev_delay);

    assign busy       = (st_q != S_IDLE) || !ldac_q;
    assign word_ready = !busy && (num_dev != '0) && (wcnt_q < num_dev);
    assign accept     = word_valid && word_ready;
    assign last_bit   = (fidx_q == num_dev - ONE_D) && (bidx_q == 4'd9);
    assign bit_val    = (bidx_q == 4'd10) ? 1'b0 : store_bit;

    dac_word_store #(.MAX_DEV(MAX_DEV), .IDX_W(DEV_W), .WORD_W(WORD_W)) i_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(accept), .wr_idx(wcnt_q), .wr_word(word_in),
        .rd_idx(fidx_q), .rd_bit(bidx_q), .rd_value(store_bit)
    );

    dac_phase_timer #(.W(EXT_W)) i_timer (
        .clk(clk), .rst_n(rst_n),
        .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:     if (num_dev != '0 && wcnt_q == num_dev) st_d = S_START_A;
            S_START_A:  if (tmr_done) st_d = S_START_B;
            S_START_B:  if (tmr_done) st_d = S_BIT_LO;
            S_BIT_LO:   if (tmr_done) st_d = S_BIT_HI;
            S_BIT_HI:   if (tmr_done) st_d = last_bit ? S_STOP_LO : S_BIT_LO;
            S_STOP_LO:  if (tmr_done) st_d = S_STOP_SCL;
            S_STOP_SCL: if (tmr_done) st_d = S_STOP_SDA;
            S_STOP_SDA: if (tmr_done) st_d = S_LDAC;
            S_LDAC:     if (tmr_done) st_d = S_IDLE;
            default:    st_d = S_IDLE;
        endcase
    end

    always_comb begin
        tmr_load = (st_d != st_q);
        unique case (st_d)
            S_STOP_SCL, S_STOP_SDA: tmr_val = stop_ext - 1'b1;
            S_LDAC:                 tmr_val = ldac_ext - 1'b1;
            default:                tmr_val = half_ext - 1'b1;
        endcase
    end

    // state register and indices
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            wcnt_q <= '0;
            fidx_q <= '0;
            bidx_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == S_IDLE) begin
                fidx_q <= '0;
                bidx_q <= '0;
                if (st_d == S_START_A)
                    wcnt_q <= '0;
                else if (accept)
                    wcnt_q <= wcnt_q + ONE_D;
            end else if (st_q == S_BIT_HI && tmr_done && !last_bit) begin
                if (bidx_q == 4'd10) begin
                    bidx_q <= '0;
                    fidx_q <= fidx_q + ONE_D;
                end else begin
                    bidx_q <= bidx_q + 4'd1;
                end
            end
        end
    end

    // line outputs
    always_comb begin
        scl_c = 1'b1; sda_c = 1'b1; ldac_c = 1'b1;
        unique case (st_q)
            S_IDLE:     ;
            S_START_A:  sda_c = 1'b0;
            S_START_B:  begin scl_c = 1'b0; sda_c = 1'b0; end
            S_BIT_LO:   begin scl_c = 1'b0; sda_c = bit_val; end
            S_BIT_HI:   sda_c = bit_val;
            S_STOP_LO:  begin scl_c = 1'b0; sda_c = 1'b0; end
            S_STOP_SCL: sda_c = 1'b0;
            S_STOP_SDA: ;
            S_LDAC:     ldac_c = 1'b0;
            default:    ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1; sda_q <= 1'b1; ldac_q <= 1'b1;
        end else begin
            scl_q <= scl_c; sda_q <= sda_c; ldac_q <= ldac_c;
        end
    end

    assign scl    = scl_q;
    assign sda    = sda_q;
    assign ldac_n = ldac_q;

    p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE && $past(st_q) == S_IDLE) |-> (scl && sda && ldac_n));

    p_start_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (scl && $past(scl) && $fell(sda)) |-> ($past(st_q) == S_START_A));

    p_frame_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_BIT_HI) |-> (fidx_q < num_dev && bidx_q <= 4'd10));

    p_stop_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (scl && $past(scl) && $rose(sda)) |-> ($past(st_q) == S_STOP_SDA));

    p_ldac_after_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ldac_n) |-> (scl && sda));

    p_no_take_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != S_IDLE) |=> (wcnt_q == $past(wcnt_q) || st_q == S_IDLE));
endmodule

// File: tb/test_cascade_dac_loader.sv
module test_cascade_dac_loader;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_DEV = 8;
    localparam int CNT_W = 16;
    localparam int DEV_W = $clog2(MAX_DEV + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CNT_W-1:0] half_period = 16'd1, dev_delay = '0, ldac_width = 16'd1;
    logic [DEV_W-1:0] num_dev = DEV_W'(1);
    logic word_valid = 1'b0;
    logic [9:0] word_in = '0;
    logic word_ready, busy, scl, sda, ldac_n;

    int n_tests = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cascade_dac_loader #(.MAX_DEV(MAX_DEV), .CNT_W(CNT_W)) i_cascade_dac_loader (
        .clk(clk), .rst_n(rst_n), .half_period(half_period), .num_dev(num_dev),
        .dev_delay(dev_delay), .ldac_width(ldac_width), .word_valid(word_valid),
        .word_in(word_in), .word_ready(word_ready), .busy(busy), .scl(scl),
        .sda(sda), .ldac_n(ldac_n)
    );

    // line monitor
    int cyc = 0, n_start, n_stop, ncap, n_hbad, n_ldbad, n_busybad;
    int t_start, t_sclr, t_sdar, t_ldf, start_len, stop_len, ldac_gap, ldac_w, cur_h;
    bit in_frame, first_fall;
    logic cap [128];
    logic p_scl = 1'b1, p_sda = 1'b1, p_ldac = 1'b1;

    task automatic clear_mon();
        n_start = 0; n_stop = 0; ncap = 0; n_hbad = 0; n_ldbad = 0; n_busybad = 0;
        start_len = -1; stop_len = -1; ldac_gap = -1; ldac_w = -1;
        in_frame = 0; first_fall = 0;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (scl && p_scl && sda != p_sda) begin
                if (!sda) begin
                    n_start++; t_start = cyc; in_frame = 1; first_fall = 1;
                end else begin
                    n_stop++; t_sdar = cyc; stop_len = cyc - t_sclr; in_frame = 0;
                end
            end
            if (!scl && p_scl && in_frame) begin
                if (first_fall) begin
                    first_fall = 0; start_len = cyc - t_start;
                end else begin
                    if (ncap < 128) cap[ncap] = p_sda;
                    ncap++;
                    if (cyc - t_sclr != cur_h) n_hbad++;
                end
            end
            if (scl && !p_scl) t_sclr = cyc;
            if (!ldac_n && p_ldac) begin
                t_ldf = cyc; ldac_gap = cyc - t_sdar;
                if (!scl || !sda) n_ldbad++;
            end
            if (ldac_n && !p_ldac) ldac_w = cyc - t_ldf;
            if (!ldac_n && !busy) n_busybad++;
        end
        p_scl = scl; p_sda = sda; p_ldac = ldac_n;
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic push_word(input logic [9:0] w);
        @(negedge clk);
        word_valid = 1'b1;
        word_in = w;
        while (!word_ready) @(negedge clk);
        @(negedge clk);
        word_valid = 1'b0;
    endtask

    task automatic run_txn(input int n, input int h, input int d, input int w,
                           input logic [9:0] words [8], input bit poke, input string name);
        logic exp_bits [128];
        int nexp = 0, mism = 0, first_bad = -1, rdy_bad = 0, guard = 0;
        int he = (h == 0) ? 1 : h;
        int we = (w == 0) ? 1 : w;
        num_dev = DEV_W'(n); half_period = CNT_W'(h);
        dev_delay = CNT_W'(d); ldac_width = CNT_W'(w);
        cur_h = he;
        clear_mon();
        @(negedge clk);
        check(word_ready == 1'b1 && busy == 1'b0, {name, " R2 ready before words"}, word_ready, 1);
        for (int k = 0; k < n; k++) push_word(words[k]);
        while (!busy && guard < 50) begin @(negedge clk); guard++; end
        check(busy == 1'b1, {name, " R2 busy after last word"}, busy, 1);
        if (poke) begin
            word_valid = 1'b1; word_in = 10'h3A5;
            for (int c = 0; c < 30; c++) begin
                @(negedge clk);
                if (word_ready) rdy_bad++;
            end
            word_valid = 1'b0;
            check(rdy_bad == 0, {name, " R9 ready low while busy"}, rdy_bad, 0);
        end
        guard = 0;
        while (busy && guard < 20000) begin @(negedge clk); guard++; end
        @(negedge clk);
        for (int k = 0; k < n; k++) begin
            for (int b = 9; b >= 0; b--) begin exp_bits[nexp] = words[k][b]; nexp++; end
            if (k < n - 1) begin exp_bits[nexp] = 1'b0; nexp++; end
        end
        for (int i = 0; i < nexp && i < ncap; i++)
            if (cap[i] !== exp_bits[i]) begin
                mism++;
                if (first_bad < 0) first_bad = i;
            end
        check(n_start == 1, {name, " R3 one start"}, n_start, 1);
        check(start_len == he, {name, " R3 start to clock fall"}, start_len, he);
        check(ncap == 11 * n - 1, {name, " R5 bit count"}, ncap, 11 * n - 1);
        check(mism == 0, {name, " R4 word bits in order"}, first_bad, -1);
        check(n_hbad == 0, {name, " R10 clock high phase"}, n_hbad, 0);
        check(n_stop == 1, {name, " R6 R7 single stop, no data change in high phase"}, n_stop, 1);
        check(stop_len == he + n * d, {name, " R7 stop setup"}, stop_len, he + n * d);
        check(ldac_gap == he + n * d, {name, " R8 stop to strobe"}, ldac_gap, he + n * d);
        check(ldac_w == we, {name, " R8 strobe width"}, ldac_w, we);
        check(n_ldbad == 0, {name, " R8 strobe with lines high"}, n_ldbad, 0);
        check(n_busybad == 0, {name, " R9 busy during strobe"}, n_busybad, 0);
        check(scl && sda && ldac_n && !busy && word_ready, {name, " R1 R2 idle after"},
              {scl, sda, ldac_n, busy, word_ready}, 5'b11101);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(scl && sda && ldac_n && !busy, "R1 reset lines", {scl, sda, ldac_n, busy}, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);
        check(word_ready == 1'b1, "R2 ready after reset", word_ready, 1);
    endtask

    task automatic t_single();
        logic [9:0] ws [8];
        foreach (ws[i]) ws[i] = '0;
        ws[0] = {2'b10, 8'hB4};
        run_txn(1, 2, 3, 4, ws, 0, "single");
    endtask

    task automatic t_chain_poke();
        logic [9:0] ws [8];
        foreach (ws[i]) ws[i] = '0;
        ws[0] = {2'b01, 8'hFF}; ws[1] = {2'b11, 8'h01}; ws[2] = {2'b00, 8'h80};
        run_txn(3, 3, 2, 2, ws, 1, "chain3_poke");
    endtask

    task automatic t_min_timing();
        logic [9:0] ws [8];
        foreach (ws[i]) ws[i] = '0;
        ws[0] = 10'h155; ws[1] = 10'h2AA; ws[2] = 10'h3FF; ws[3] = 10'h000;
        run_txn(4, 0, 0, 0, ws, 0, "chain4_min");
    endtask

    task automatic t_full_chain();
        logic [9:0] ws [8];
        for (int i = 0; i < 8; i++) ws[i] = 10'((i * 137 + 41) % 1024);
        run_txn(8, 1, 5, 3, ws, 0, "chain8");
    endtask

    initial begin
        t_reset();
        t_single();
        t_chain_poke();
        t_min_timing();
        t_full_chain();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog R9 actual=busy expected=idle");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule